// File: doc/BRIEF.md
# Grayscale LED Matrix Row Scanner

This block refreshes a 16 by 16 LED matrix at several brightness levels by bit-plane time multiplexing. Each row is shown once per bit plane, and each plane is held for a different number of timer ticks, so a pixel's perceived brightness follows the weighted sum of its plane bits. For every (plane, row) pair the block reads two bytes of column data from an external frame memory and presents them on two 8-bit column buses.

Rows are selected through two external 8-stage shift registers chained one after the other. Both share one shift clock and one active-low clear line, and each has its own serial data input. At row 0 the first register is cleared and loaded with a single 1. At row 8 the second register is loaded the same way. Every other row change is one shift clock. Before any row change the column buses are blanked, and a dead time is kept on both sides of the shift activity. A one-clock heartbeat marks the start of each frame. Deasserting the enable silences every output and restarts the scan.

Top module: `led_matrix_scan`

## Requirements
- R1: While reset is held, and after reset while `en` is low, both column buses, `row_clk`, `row_clr_n`, `row_dat_a`, `row_dat_b` and `frame_pulse` are 0.
- R2: After `en` rises, the first period lasts FIRST_TICKS ticks of PRESCALE clocks. The columns first show data FIRST_TICKS*PRESCALE+3 clocks after `en` rises, and that data is plane 1 of row 0.
- R3: Plane p lasts PLANE_TICKS byte p ticks (defaults 2, 5 and 22 ticks). Counted from the first blanked cycle of a row, plane 1 data appears at 2*PRESCALE+3 clocks, plane 2 data at 7*PRESCALE+3 clocks, and the next row's blanking at 29*PRESCALE clocks.
- R4: The plane advances at every period end. The row advances only when the plane wraps from 2 to 0, so a row shows planes 0, 1 and 2 in that order.
- R5: At a row change, both column buses become 0 in the cycle after the period ends. Exactly DEAD_PRE clocks then pass with all row-control lines idle (`row_clr_n`=1, others 0) before the first row-control line moves.
- R6: On a change to row 0 there is one clock with `row_clr_n`=0, then one clock with `row_dat_a`=1, then one clock with `row_clk`=1 and `row_dat_a`=1. After that all lines are idle.
- R7: On a change to row 8 the sequence is the same as in R6, but `row_dat_b` is used in place of `row_dat_a`.
- R8: On a change to any other row, `row_clk` is high for exactly one clock while both data lines stay 0 and `row_clr_n` stays 1.
- R9: After the last row-control cycle, the columns stay 0 for DEAD_POST+3 clocks. They then show plane 0 of the new row. The frame memory has one clock of read latency. `col_lo` takes the byte at address (plane*16+row)*2 and `col_hi` the byte at that address plus 1.
- R10: `frame_pulse` is high for exactly one clock, in the first blanked cycle of each change to row 0, and at no other time.
- R11: One clock after `en` is sampled low, every output of R1 is 0. Plane, row and timer restart, so re-enabling behaves as R2 describes.
- R12: The two data lines are never high together, and both are unchanged in the cycle in which `row_clk` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Scan enable; low blanks the display and restarts the scan |
| mem_rd_addr | output | AW (7) | Frame-memory read address, (plane*16+row)*2+byte |
| mem_rd_data | input | 8 | Frame-memory read data, valid one clock after the address |
| col_lo | output | 8 | Column bus for byte 0 of the row |
| col_hi | output | 8 | Column bus for byte 1 of the row |
| row_clk | output | 1 | Shared shift clock of both row registers |
| row_clr_n | output | 1 | Shared active-low clear of both row registers |
| row_dat_a | output | 1 | Serial data into the first row register (rows 0 to 7) |
| row_dat_b | output | 1 | Serial data into the second row register (rows 8 to 15) |
| frame_pulse | output | 1 | One-clock heartbeat at each frame start |

## Verification
The bench builds the block with PRESCALE set to 32 and every other parameter at its default: dead times of 10 and 20 clocks, plane weights of 2, 5 and 22 ticks, and a first period of 20 ticks. With this setting a whole frame of 16 rows takes under 15,000 clocks, so the initial partial frame, a full frame with all 16 row changes, and both register restarts at rows 0 and 8 all fit in one run. The shortest plane period is 64 clocks, which is still longer than the 36-clock blanking and shift sequence, so every weighted period and dead window can be measured exactly without one period running into the next.

// File: rtl/led_scan_pkg.sv
// Shared constants and types of the LED matrix scanner.
package led_scan_pkg;

    // Number of bit planes and column bytes per row (fixed by the bus layout).
    localparam int unsigned SCAN_PLANES = 3;
    localparam int unsigned COL_BYTES   = 2;

    // Row-change sequencer states.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_CLR,
        SQ_LOAD,
        SQ_CLKH,
        SQ_POST
    } seq_state_t;

    // What a row change does to the external shift registers.
    typedef enum logic [1:0] {
        CHAIN_FIRST,
        CHAIN_SECOND,
        CHAIN_STEP
    } shift_kind_t;

endpackage

// File: rtl/led_scan_timer.sv
// Period timer and scan position.
// Divides the clock by PRESCALE into ticks and ends a period after a number
// of ticks chosen by the plane that is being shown. The plane advances at
// every period end, and the row advances when the plane wraps.
// Assumes PRESCALE >= 2 and that every tick count is between 1 and 255.
module led_scan_timer #(
    parameter int unsigned PRESCALE    = 256,
    parameter int unsigned FIRST_TICKS = 20,
    parameter int unsigned NUM_PLANES  = 3,
    parameter int unsigned NUM_ROWS    = 16,
    parameter logic [8*NUM_PLANES-1:0] PLANE_TICKS = {8'd22, 8'd5, 8'd2},
    localparam int unsigned PLW = $clog2(NUM_PLANES),
    localparam int unsigned RW  = $clog2(NUM_ROWS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    output logic           expire,
    output logic [PLW-1:0] plane,
    output logic [RW-1:0]  row,
    output logic [PLW-1:0] next_plane,
    output logic [RW-1:0]  next_row
);
    localparam int unsigned PW = $clog2(PRESCALE);

    logic [PW-1:0] pre_q;
    logic [7:0]    tcnt_q;
    logic [7:0]    limit_q;
    logic [7:0]    next_limit;
    logic          tick;
    logic          period_end;

    assign tick       = (pre_q == PW'(PRESCALE - 1));
    assign period_end = tick && (tcnt_q == limit_q - 8'd1);
    assign expire     = en && period_end;

    // Next scan position: plane is the inner count, row the outer.
    always_comb begin
        next_plane = (plane == PLW'(NUM_PLANES - 1)) ? '0 : plane + PLW'(1);
        next_row   = row;
        if (next_plane == '0) begin
            next_row = (row == RW'(NUM_ROWS - 1)) ? '0 : row + RW'(1);
        end
        next_limit = PLANE_TICKS[8*int'(next_plane) +: 8];
    end

    // Prescaler, tick counter and scan position registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_q   <= '0;
            tcnt_q  <= '0;
            limit_q <= 8'(FIRST_TICKS);
            plane   <= '0;
            row     <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + PW'(1);
            if (period_end) begin
                tcnt_q  <= '0;
                limit_q <= next_limit;
                plane   <= next_plane;
                row     <= next_row;
            end else if (tick) begin
                tcnt_q <= tcnt_q + 8'd1;
            end
        end
    end

endmodule

// File: rtl/led_row_sequencer.sv
// Row-change sequencer.
// At a period end that changes the row, it blanks the columns, waits
// DEAD_PRE clocks and drives the shift-register controls: a clear and a load
// at the start of either register chain, or one shift clock otherwise. It
// then waits DEAD_POST clocks and requests a column fetch. A period end that
// keeps the row requests the fetch at once.
// Assumes the shortest period is longer than the whole sequence; a period
// end that arrives while the sequence is busy is not acted on.
module led_row_sequencer
    import led_scan_pkg::*;
#(
    parameter int unsigned DEAD_PRE       = 10,
    parameter int unsigned DEAD_POST      = 20,
    parameter int unsigned ROWS_PER_CHAIN = 8,
    parameter int unsigned RW             = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          expire,
    input  logic          row_change,
    input  logic [RW-1:0] next_row,
    output logic          blank,
    output logic          fetch_start,
    output logic          row_clk,
    output logic          row_clr_n,
    output logic          row_dat_a,
    output logic          row_dat_b
);
    localparam int unsigned DMAX = (DEAD_PRE > DEAD_POST) ? DEAD_PRE : DEAD_POST;
    localparam int unsigned CW   = $clog2(DMAX + 1);

    seq_state_t  state_q;
    shift_kind_t kind_q;
    logic [CW-1:0] cnt_q;
    logic        en_q;
    logic        accept;
    logic        data_on;

    assign accept      = (state_q == SQ_IDLE) && expire;
    assign blank       = accept && row_change;
    assign fetch_start = (accept && !row_change) ||
                         ((state_q == SQ_POST) && (cnt_q == CW'(DEAD_POST - 1)));

    // Decode the shift-register controls from the sequencer state.
    assign data_on   = (state_q == SQ_LOAD) || (state_q == SQ_CLKH);
    assign row_clk   = (state_q == SQ_CLKH);
    assign row_clr_n = en_q && (state_q != SQ_CLR);
    assign row_dat_a = data_on && (kind_q == CHAIN_FIRST);
    assign row_dat_b = data_on && (kind_q == CHAIN_SECOND);

    // Registered enable that gates the idle-high clear line.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Sequence state, dead-time counter and selected chain action.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= SQ_IDLE;
            kind_q  <= CHAIN_STEP;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (blank) begin
                        state_q <= SQ_PRE;
                        cnt_q   <= '0;
                        if (next_row == '0)                      kind_q <= CHAIN_FIRST;
                        else if (next_row == RW'(ROWS_PER_CHAIN)) kind_q <= CHAIN_SECOND;
                        else                                      kind_q <= CHAIN_STEP;
                    end
                end
                SQ_PRE: begin
                    if (cnt_q == CW'(DEAD_PRE - 1)) begin
                        cnt_q   <= '0;
                        state_q <= (kind_q == CHAIN_STEP) ? SQ_CLKH : SQ_CLR;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                SQ_CLR:  state_q <= SQ_LOAD;
                SQ_LOAD: state_q <= SQ_CLKH;
                SQ_CLKH: begin
                    state_q <= SQ_POST;
                    cnt_q   <= '0;
                end
                SQ_POST: begin
                    if (cnt_q == CW'(DEAD_POST - 1)) state_q <= SQ_IDLE;
                    else                             cnt_q   <= cnt_q + CW'(1);
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/led_col_fetch.sv
// Column fetch and column output registers.
// A fetch request reads the two bytes of the current (plane, row) from a
// memory with one clock of read latency, then loads both column buses
// together three clocks after the request. A blank request clears both buses.
// Assumes plane and row are stable while a fetch is in flight.
module led_col_fetch #(
    parameter int unsigned NUM_ROWS = 16,
    parameter int unsigned PLW      = 2,
    parameter int unsigned RW       = 4,
    parameter int unsigned AW       = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           blank,
    input  logic           fetch_start,
    input  logic [PLW-1:0] plane,
    input  logic [RW-1:0]  row,
    input  logic [7:0]     rd_data,
    output logic [AW-1:0]  rd_addr,
    output logic [7:0]     col_lo,
    output logic [7:0]     col_hi
);
    localparam int unsigned LW = AW - 1;

    logic [2:0]    stage_q;
    logic [7:0]    hold_q;
    logic [LW-1:0] line_idx;

    // Row-line index in memory; the low address bit selects the byte.
    assign line_idx = LW'(plane) * LW'(NUM_ROWS) + LW'(row);
    assign rd_addr  = {line_idx, stage_q[1]};

    // Fetch pipeline: address byte 0, address byte 1, load both.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) stage_q <= '0;
        else               stage_q <= {stage_q[1:0], fetch_start};
    end

    // Hold byte 0 and update both column buses at once.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hold_q <= '0;
            col_lo <= '0;
            col_hi <= '0;
        end else begin
            if (stage_q[1]) hold_q <= rd_data;
            if (blank) begin
                col_lo <= '0;
                col_hi <= '0;
            end else if (stage_q[2]) begin
                col_lo <= hold_q;
                col_hi <= rd_data;
            end
        end
    end

endmodule

// File: rtl/led_matrix_scan.sv
// LED matrix scan controller top.
// Connects the period timer, the row-change sequencer and the column fetch,
// and produces the once-per-frame heartbeat.
// Assumes a 16-row matrix built from two chained row registers of
// ROWS_PER_CHAIN stages and a synchronous frame memory.
module led_matrix_scan
    import led_scan_pkg::*;
#(
    parameter int unsigned PRESCALE       = 256,
    parameter int unsigned FIRST_TICKS    = 20,
    parameter logic [8*SCAN_PLANES-1:0] PLANE_TICKS = {8'd22, 8'd5, 8'd2},
    parameter int unsigned DEAD_PRE       = 10,
    parameter int unsigned DEAD_POST      = 20,
    parameter int unsigned ROWS_PER_CHAIN = 8,
    localparam int unsigned NUM_ROWS = 2 * ROWS_PER_CHAIN,
    localparam int unsigned AW       = $clog2(SCAN_PLANES * NUM_ROWS * COL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic [7:0]    col_lo,
    output logic [7:0]    col_hi,
    output logic          row_clk,
    output logic          row_clr_n,
    output logic          row_dat_a,
    output logic          row_dat_b,
    output logic          frame_pulse
);
    localparam int unsigned PLW = $clog2(SCAN_PLANES);
    localparam int unsigned RW  = $clog2(NUM_ROWS);

    logic           expire;
    logic [PLW-1:0] plane;
    logic [RW-1:0]  row;
    logic [PLW-1:0] next_plane;
    logic [RW-1:0]  next_row;
    logic           row_change;
    logic           blank;
    logic           fetch_start;

    assign row_change = (next_plane == '0);

    led_scan_timer #(
        .PRESCALE    (PRESCALE),
        .FIRST_TICKS (FIRST_TICKS),
        .NUM_PLANES  (SCAN_PLANES),
        .NUM_ROWS    (NUM_ROWS),
        .PLANE_TICKS (PLANE_TICKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .expire     (expire),
        .plane      (plane),
        .row        (row),
        .next_plane (next_plane),
        .next_row   (next_row)
    );

    led_row_sequencer #(
        .DEAD_PRE       (DEAD_PRE),
        .DEAD_POST      (DEAD_POST),
        .ROWS_PER_CHAIN (ROWS_PER_CHAIN),
        .RW             (RW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .expire      (expire),
        .row_change  (row_change),
        .next_row    (next_row),
        .blank       (blank),
        .fetch_start (fetch_start),
        .row_clk     (row_clk),
        .row_clr_n   (row_clr_n),
        .row_dat_a   (row_dat_a),
        .row_dat_b   (row_dat_b)
    );

    led_col_fetch #(
        .NUM_ROWS (NUM_ROWS),
        .PLW      (PLW),
        .RW       (RW),
        .AW       (AW)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .blank       (blank),
        .fetch_start (fetch_start),
        .plane       (plane),
        .row         (row),
        .rd_data     (mem_rd_data),
        .rd_addr     (mem_rd_addr),
        .col_lo      (col_lo),
        .col_hi      (col_hi)
    );

    // Heartbeat: one clock when the scan wraps back to row 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) frame_pulse <= 1'b0;
        else               frame_pulse <= expire && row_change && (next_row == '0);
    end

endmodule

// File: rtl/led_matrix_scan_chk.sv
// Protocol checker for the LED matrix scanner, bound to the top module.
// Watches only the top-level ports.
module led_matrix_scan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [7:0] col_lo,
    input logic [7:0] col_hi,
    input logic       row_clk,
    input logic       row_clr_n,
    input logic       row_dat_a,
    input logic       row_dat_b,
    input logic       frame_pulse
);
    // R5: columns are dark whenever a row-control line is active.
    assert_dark_while_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_clk || row_dat_a || row_dat_b || !row_clr_n) |-> (col_lo == 8'd0 && col_hi == 8'd0));

    // R12: never both data lines at once.
    assert_one_data_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_dat_a, row_dat_b}));

    // R12: data lines hold still as the shift clock rises.
    assert_data_stable_at_clk_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_clk) |-> $stable({row_dat_a, row_dat_b}));

    // R8: the shift clock pulse is a single clock wide.
    assert_clk_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        row_clk |=> !row_clk);

    // R6: the clear pulse is a single clock wide while enabled.
    assert_clear_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !row_clr_n && $past(row_clr_n)) |=> row_clr_n);

    // R10: heartbeat lasts one clock and falls in a dark cycle.
    assert_heartbeat_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !frame_pulse);
    assert_heartbeat_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (col_lo == 8'd0 && col_hi == 8'd0));

    // R11: one clock after enable is low every output is quiet.
    assert_disable_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (col_lo == 8'd0 && col_hi == 8'd0 && !row_clk && !row_clr_n &&
                 !row_dat_a && !row_dat_b && !frame_pulse));

endmodule

bind led_matrix_scan led_matrix_scan_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .col_lo      (col_lo),
    .col_hi      (col_hi),
    .row_clk     (row_clk),
    .row_clr_n   (row_clr_n),
    .row_dat_a   (row_dat_a),
    .row_dat_b   (row_dat_b),
    .frame_pulse (frame_pulse)
);

// File: tb/sim_led_matrix_scan.sv
// Self-checking bench for the LED matrix scanner.
module sim_led_matrix_scan;
    localparam int P    = 32;
    localparam int DP   = 10;
    localparam int DQ   = 20;
    localparam int AW   = 7;

    // Expected chain action per row in frame order: 0 first chain,
    // 1 second chain, 2 single shift.
    localparam logic [1:0] ROW_KIND [16] = '{
        2'd0, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2,
        2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data;
    logic [7:0]    col_lo;
    logic [7:0]    col_hi;
    logic          row_clk;
    logic          row_clr_n;
    logic          row_dat_a;
    logic          row_dat_b;
    logic          frame_pulse;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    led_matrix_scan #(.PRESCALE(P)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .col_lo      (col_lo),
        .col_hi      (col_hi),
        .row_clk     (row_clk),
        .row_clr_n   (row_clr_n),
        .row_dat_a   (row_dat_a),
        .row_dat_b   (row_dat_b),
        .frame_pulse (frame_pulse)
    );

    // Frame-memory content: distinct and nonzero for every used address.
    function automatic logic [7:0] patt(input int a);
        return 8'((a * 7 + 49) & 255);
    endfunction

    // Synchronous frame memory with one clock of read latency.
    always_ff @(posedge clk) mem_rd_data <= patt(int'(mem_rd_addr));

    function automatic bit ctl_idle();
        return row_clr_n && !row_clk && !row_dat_a && !row_dat_b;
    endfunction

    function automatic bit all_quiet();
        return col_lo == 0 && col_hi == 0 && !row_clk && !row_clr_n &&
               !row_dat_a && !row_dat_b && !frame_pulse;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Enable and time the first column update (R2 / R11 restart).
    task automatic first_update(input string req);
        int k;
        en = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (col_lo == 0 && col_hi == 0 && k < 2000);
        chk(k == 20 * P + 3, req, k, 20 * P + 3);
        chk(col_lo == patt(32) && col_hi == patt(33), req, int'(col_lo), int'(patt(32)));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int g;
        rst_n = 1'b0;
        en    = 1'b0;
        repeat (3) @(negedge clk);
        chk(all_quiet(), "R1 in reset", int'(row_clr_n), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(all_quiet(), "R1 idle after reset", int'(col_lo), 0);

        first_update("R2");

        // Reach the start of a frame.
        g = 0;
        while (!frame_pulse && g < 40000) begin
            @(negedge clk);
            g++;
        end
        chk(frame_pulse, "R10 heartbeat seen", int'(frame_pulse), 1);

        // Walk one full frame, row by row, from the table.
        for (int i = 0; i < 16; i++) begin
            int t;
            int n;
            int m;
            bit da;
            bit db;
            t  = 0;
            da = (ROW_KIND[i] == 2'd0);
            db = (ROW_KIND[i] == 2'd1);
            chk(col_lo == 0 && col_hi == 0, "R5 blank at row change", int'(col_lo), 0);
            chk(frame_pulse == (i == 0), "R10 heartbeat only at row 0", int'(frame_pulse), int'(i == 0));

            n = 0;
            while (ctl_idle() && n < 100) begin
                @(negedge clk);
                n++;
                t++;
                if (n < DP) chk(col_lo == 0 && col_hi == 0, "R5 dark in dead time", int'(col_lo), 0);
            end
            chk(n == DP, "R5 pre dead time", n, DP);

            if (ROW_KIND[i] != 2'd2) begin
                chk(!row_clr_n && !row_clk && !row_dat_a && !row_dat_b,
                    da ? "R6 clear" : "R7 clear", int'(row_clr_n), 0);
                @(negedge clk); t++;
                chk(row_clr_n && !row_clk && row_dat_a == da && row_dat_b == db,
                    da ? "R6 load" : "R7 load", int'({row_dat_a, row_dat_b}), int'({da, db}));
                @(negedge clk); t++;
                chk(row_clr_n && row_clk && row_dat_a == da && row_dat_b == db,
                    da ? "R6 shift" : "R7 shift", int'(row_clk), 1);
                chk(!(row_dat_a && row_dat_b) && (row_dat_a || row_dat_b), "R12 data held at clock",
                    int'({row_dat_a, row_dat_b}), int'({da, db}));
            end else begin
                chk(row_clk && row_clr_n && !row_dat_a && !row_dat_b, "R8 single shift",
                    int'({row_clk, row_dat_a, row_dat_b}), 4);
            end
            chk(col_lo == 0 && col_hi == 0, "R5 dark during shift", int'(col_lo), 0);

            @(negedge clk); t++;
            chk(ctl_idle(), "R8 controls idle after shift", int'(row_clk), 0);
            m = 0;
            while (col_lo == 0 && col_hi == 0 && m < 200) begin
                @(negedge clk);
                m++;
                t++;
            end
            chk(m == DQ + 3, "R9 post dead time", m, DQ + 3);
            chk(col_lo == patt(i * 2), "R9 plane0 low byte", int'(col_lo), int'(patt(i * 2)));
            chk(col_hi == patt(i * 2 + 1), "R9 plane0 high byte", int'(col_hi), int'(patt(i * 2 + 1)));

            while (col_lo != patt((16 + i) * 2) && t < 3000) begin
                @(negedge clk);
                t++;
            end
            chk(t == 2 * P + 3, "R3 plane1 start", t, 2 * P + 3);
            chk(col_hi == patt((16 + i) * 2 + 1), "R4 plane1 same row", int'(col_hi), int'(patt((16 + i) * 2 + 1)));

            while (col_lo != patt((32 + i) * 2) && t < 3000) begin
                @(negedge clk);
                t++;
            end
            chk(t == 7 * P + 3, "R3 plane2 start", t, 7 * P + 3);
            chk(col_hi == patt((32 + i) * 2 + 1), "R4 plane2 same row", int'(col_hi), int'(patt((32 + i) * 2 + 1)));

            while (!(col_lo == 0 && col_hi == 0) && t < 3000) begin
                @(negedge clk);
                t++;
            end
            chk(t == 29 * P, "R3 row period", t, 29 * P);
        end
        chk(frame_pulse, "R10 next frame heartbeat", int'(frame_pulse), 1);

        // Disable in mid-scan, then restart.
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(all_quiet(), "R11 quiet after disable", int'({col_lo, row_clr_n}), 0);
        repeat (50) @(negedge clk);
        chk(all_quiet(), "R11 stays quiet", int'({col_lo, row_clr_n}), 0);
        first_update("R11 restart");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule